// File: doc/BRIEF.md
# Phase-Accumulating Sine Oscillator with Quadrant Folding

This block is a numerically controlled oscillator. Each enabled clock it adds an unsigned tuning word to a wide phase register, and the register wraps modulo 2^ACC_W. The output tone frequency is therefore tune_word × f_clk / 2^ACC_W, so one step of the tuning word moves the frequency by f_clk / 2^ACC_W.

Only the upper PH_W bits of the phase go on to amplitude generation. Of those bits, the top two name the quadrant. The rest index a table that holds a single quarter of a sine wave. The table is filled with values computed at elaboration time. Descending quadrants read it in mirrored order, and the lower half-cycle is negated. The result is a full signed sine from a quarter of the storage. The lookup is registered, and the output gets its own register stage, so an amplitude sample and its valid flag come out at a fixed latency.

Top module: `nco_quarter_sine`

## Requirements
- R1: On each rising edge with `en` high, the phase register becomes (phase + `tune_word`) mod 2^ACC_W. The output sequence follows this phase, including wrap-around past 2^ACC_W.
- R2: Given a tuning word M that divides 2^ACC_W, the output sequence repeats every 2^ACC_W / M valid samples.
- R3: Only phase bits [ACC_W-1 : ACC_W-PH_W] select the amplitude. Carries from the discarded low bits still advance the phase exactly.
- R4: Table index k is phase bits [ACC_W-3 : ACC_W-PH_W]. The quadrant code q is the top two bits. In quadrants 1 and 3 (q[0]=1) the table is read at the bitwise complement of k. In quadrants 0 and 2 it is read at k.
- R5: The magnitude is T(idx) = round((2^(AMP_W-1)-1) × sin(2π·idx / 2^PH_W)). In quadrants 2 and 3 (q[1]=1) the output is its two's-complement negation. In quadrants 0 and 1 the output is T itself.
- R6: A change of `tune_word` takes effect on the next enabled addition and does not reset the phase.
- R7: If `en` is sampled high at edge k, then `amp_valid` is high after edge k+1 and `amp_out` carries the amplitude of the phase held at edge k. If `en` is low at edge k, then `amp_valid` is low after edge k+1.
- R8: While `en` is low, the phase holds and `amp_out` keeps its last value.
- R9: A synchronous high `rst` clears the phase to 0, `amp_out` to 0 and `amp_valid` to 0. The first sample after reset has phase 0 and amplitude 0.
- R10: The output spans ±(2^(AMP_W-1)-1). The most negative code never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and issue one sample |
| tune_word | input | ACC_W | Phase increment per enabled clock |
| amp_out | output | AMP_W | Signed sine amplitude |
| amp_valid | output | 1 | amp_out holds a new sample |

## Verification
An enable sampled at one rising edge is registered in the lookup stage on that same edge, and its sample reaches the ports after the following edge. The output therefore trails the phase by two edges, and a stretch of low enable empties the valid flag two edges later. The bench drives inputs on falling edges and advances its own arithmetic model by one stage per rising edge. It compares `amp_valid` and `amp_out` at the next falling edge, every cycle, so every sample is checked at exactly the cycle in which it is due.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    QD_RISE     = 2'd0,
    QD_FALL     = 2'd1,
    QD_NEG_FALL = 2'd2,
    QD_NEG_RISE = 2'd3
  } quadrant_e;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded quarter-wave magnitude for table index idx.
  function automatic int sine_mag(input int idx, input int ph_w, input int amp_w);
    real peak;
    real ang;
    peak = real'((1 << (amp_w - 1)) - 1);
    ang  = TWO_PI * real'(idx) / real'(1 << ph_w);
    return $rtoi($floor(peak * $sin(ang) + 0.5));
  endfunction

  // Descending quadrants read the table backwards.
  function automatic logic quad_mirrors(input quadrant_e q);
    return (q == QD_FALL) || (q == QD_NEG_RISE);
  endfunction

  // Lower half-cycle is negated.
  function automatic logic quad_negates(input quadrant_e q);
    return (q == QD_NEG_FALL) || (q == QD_NEG_RISE);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] tune,
  output logic [ACC_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst)     phase <= '0;
    else if (en) phase <= phase + tune;
  end

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom
  import nco_pkg::*;
#(
  parameter int PH_W  = 13,
  parameter int AMP_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PH_W-1:0]  phase_top,
  output logic [AMP_W-2:0] mag_q,
  output logic             neg_q,
  output logic             vld_q
);

  localparam int IDX_W = PH_W - 2;
  localparam int QN    = 1 << IDX_W;
  localparam int MAG_W = AMP_W - 1;

  logic [MAG_W-1:0] rom_tbl [QN];

  for (genvar i = 0; i < QN; i++) begin : g_entry
    localparam logic [MAG_W-1:0] ENTRY = MAG_W'(sine_mag(i, PH_W, AMP_W));
    assign rom_tbl[i] = ENTRY;
  end

  quadrant_e        quad;
  logic [IDX_W-1:0] raw_idx;
  logic [IDX_W-1:0] rd_idx;

  assign quad    = quadrant_e'(phase_top[PH_W-1 -: 2]);
  assign raw_idx = phase_top[IDX_W-1:0];
  assign rd_idx  = quad_mirrors(quad) ? ~raw_idx : raw_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) begin
        mag_q <= rom_tbl[rd_idx];
        neg_q <= quad_negates(quad);
      end
    end
  end

endmodule

// File: rtl/nco_unfold.sv
module nco_unfold #(
  parameter int AMP_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_in,
  input  logic                    neg_in,
  input  logic [AMP_W-2:0]        mag_in,
  output logic signed [AMP_W-1:0] amp,
  output logic                    amp_vld
);

  logic signed [AMP_W-1:0] pos_val;
  assign pos_val = $signed({1'b0, mag_in});

  always_ff @(posedge clk) begin
    if (rst) begin
      amp     <= '0;
      amp_vld <= 1'b0;
    end else begin
      amp_vld <= vld_in;
      if (vld_in) amp <= neg_in ? -pos_val : pos_val;
    end
  end

endmodule

// File: rtl/nco_quarter_sine.sv
module nco_quarter_sine #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 13,
  parameter int AMP_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        tune_word,
  output logic signed [AMP_W-1:0] amp_out,
  output logic                    amp_valid
);

  logic [ACC_W-1:0] phase_acc_q;
  logic [PH_W-1:0]  phase_top;
  logic             stage1_vld;
  logic             stage1_neg;
  logic [AMP_W-2:0] stage1_mag;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .tune  (tune_word),
    .phase (phase_acc_q)
  );

  assign phase_top = phase_acc_q[ACC_W-1 -: PH_W];

  nco_quarter_rom #(.PH_W(PH_W), .AMP_W(AMP_W)) u_rom (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .phase_top (phase_top),
    .mag_q     (stage1_mag),
    .neg_q     (stage1_neg),
    .vld_q     (stage1_vld)
  );

  nco_unfold #(.AMP_W(AMP_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .vld_in  (stage1_vld),
    .neg_in  (stage1_neg),
    .mag_in  (stage1_mag),
    .amp     (amp_out),
    .amp_vld (amp_valid)
  );

endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 14
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        tune_word,
  input logic [ACC_W-1:0]        phase_acc_q,
  input logic                    stage1_vld,
  input logic                    stage1_neg,
  input logic [AMP_W-2:0]        stage1_mag,
  input logic signed [AMP_W-1:0] amp_out,
  input logic                    amp_valid
);

  localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  // R1
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> phase_acc_q == ACC_W'($past(phase_acc_q) + $past(tune_word)));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase_acc_q));

  // R7
  stage_fill_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> stage1_vld);

  // R7
  stage_drain_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !stage1_vld);

  // R7
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    stage1_vld |=> amp_valid);

  // R7
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !stage1_vld |=> !amp_valid);

  // R5
  neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (stage1_vld && stage1_neg && stage1_mag != '0) |=> amp_out[AMP_W-1]);

  // R5
  pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (stage1_vld && !stage1_neg) |=> !amp_out[AMP_W-1]);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stage1_vld |=> $stable(amp_out));

  // R10
  no_most_neg_chk: assert property (@(posedge clk) disable iff (rst)
    amp_out != MOST_NEG);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (phase_acc_q == '0) && !amp_valid && (amp_out == '0));

endmodule

bind nco_quarter_sine nco_checker #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_nco_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .tune_word   (tune_word),
  .phase_acc_q (phase_acc_q),
  .stage1_vld  (stage1_vld),
  .stage1_neg  (stage1_neg),
  .stage1_mag  (stage1_mag),
  .amp_out     (amp_out),
  .amp_valid   (amp_valid)
);

// File: tb/tb_nco_quarter_sine.sv
module tb_nco_quarter_sine;

  localparam int  AW   = 24;
  localparam int  PW   = 13;
  localparam int  MW   = 14;
  localparam int  QN   = 1 << (PW - 2);
  localparam int  PEAK = (1 << (MW - 1)) - 1;
  localparam longint MOD = 64'd1 << AW;
  localparam real PI2  = 2.0 * 3.141592653589793;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 en  = 1'b0;
  logic [AW-1:0]        tune_word = '0;
  logic signed [MW-1:0] amp_out;
  logic                 amp_valid;

  int errors = 0;
  int checks = 0;
  string tag = "R9";

  longint macc = 0;
  bit     s1_v = 0;
  int     s1_amp = 0;
  bit     e_v = 0;
  int     e_amp = 0;
  int     seen_max = -100000;
  int     seen_min = 100000;
  int     rec [1024];
  int     rec_n = 0;
  bit     recording = 0;

  always #4 clk = ~clk;

  nco_quarter_sine #(.ACC_W(AW), .PH_W(PW), .AMP_W(MW)) dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tune_word (tune_word),
    .amp_out   (amp_out),
    .amp_valid (amp_valid)
  );

  function automatic int ref_amp(input longint p);
    longint top;
    int quad;
    int k;
    int m;
    real v;
    top  = p >> (AW - PW);
    quad = int'(top / QN);
    k    = int'(top % QN);
    if (quad == 1 || quad == 3) k = QN - 1 - k;
    v = real'(PEAK) * $sin(PI2 * real'(k) / real'(1 << PW));
    m = $rtoi($floor(v + 0.5));
    return (quad >= 2) ? -m : m;
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst  = 1'b0;
    macc = 0; s1_v = 0; e_v = 0; e_amp = 0;
    check_int("R9", "valid after reset", int'(amp_valid), 0);
    check_int("R9", "amp after reset", int'(amp_out), 0);
  endtask

  // Called at a falling edge: drive, run one rising edge, compare at next falling edge.
  task automatic step(input bit e, input longint m);
    en = e;
    tune_word = AW'(m);
    @(posedge clk);
    e_v = s1_v;
    if (s1_v) e_amp = s1_amp;
    s1_v = e;
    if (e) begin
      s1_amp = ref_amp(macc);
      macc = (macc + m) % MOD;
    end
    @(negedge clk);
    check_int(tag, "valid", int'(amp_valid), int'(e_v));
    check_int(tag, "amp", int'(amp_out), e_amp);
    if (amp_valid) begin
      if (int'(amp_out) > seen_max) seen_max = int'(amp_out);
      if (int'(amp_out) < seen_min) seen_min = int'(amp_out);
      if (recording && rec_n < 1024) begin
        rec[rec_n] = int'(amp_out);
        rec_n++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9: reset state and the first sample at phase 0
    do_reset();
    tag = "R9";
    step(1, 64'd12345);
    step(0, 64'd12345);
    check_int("R9", "first sample amp", int'(amp_out), 0);
    check_int("R9", "first sample valid", int'(amp_valid), 1);

    // R4 R5 R10: one sample per table point over the whole cycle
    do_reset();
    tag = "R4 R5 sweep";
    seen_max = -100000; seen_min = 100000;
    for (int i = 0; i < (1 << PW) + 2; i++) step(1, 64'd1 << (AW - PW));
    check_int("R10", "max amplitude", seen_max, PEAK);
    check_int("R10", "min amplitude", seen_min, -PEAK);

    // R3: tuning word with low bits that are dropped before the table
    do_reset();
    tag = "R3 truncation";
    for (int i = 0; i < 3000; i++) step(1, 64'h000555);

    // R1: wrap modulo 2^ACC_W, stepping backwards and with a large word
    tag = "R1 wrap";
    for (int i = 0; i < 200; i++) step(1, MOD - 64'd2048);
    for (int i = 0; i < 200; i++) step(1, 64'h7FFFFF);

    // R6: retune on the fly, phase continues
    tag = "R6 retune";
    for (int i = 0; i < 100; i++) step(1, 64'd40000);
    for (int i = 0; i < 100; i++) step(1, 64'd91001);

    // R7 R8: enable gaps
    tag = "R7 R8 gaps";
    for (int i = 0; i < 300; i++) step((i % 3) != 0, 64'd70001 + longint'(i));
    for (int i = 0; i < 5; i++) step(0, 64'd999);
    check_int("R8", "valid idle", int'(amp_valid), 0);

    // R2: period of 2^AW / M samples
    do_reset();
    tag = "R2 period";
    recording = 1; rec_n = 0;
    for (int i = 0; i < 1030; i++) step(1, 64'd2048 * 16);
    recording = 0;
    for (int i = 0; i < 512; i++) check_int("R2", "repeat after 512", rec[i + 512], rec[i]);
    check_int("R2", "quarter-period peak", rec[128], PEAK);
    check_int("R2", "half-period zero", rec[256], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule